// File: doc/BRIEF.md
# Valid-Only to Stream Adapter with Frame Marker

This block joins a producer that speaks a reduced protocol (a data word plus a valid strobe, and a stall input it obeys one cycle late) to a full stream master port with a valid/ready handshake and an end-of-frame marker. The stream ready input is turned into an enable for the producer. The producer may push one more word in the cycle after that enable drops. A single spare register catches that word, so nothing is lost while the output is stalled.

The end-of-frame marker is made inside the block. A counter tallies accepted words and flags the word that brings the tally to a programmable frame length. The length register is loaded through a one-cycle write strobe at any time. A write clears the tally, so the next marker can arrive before a full frame has passed. Any end-of-frame flag that comes with the producer's words is discarded.

Top module: `strm_frame_adapter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `m_tvalid` is 0 and `src_ready` is 1.
- R2: Every word presented with `src_valid` high in a cycle after one where `src_ready` was high appears on `m_tdata` exactly once, in order, even when `src_ready` has just fallen in that cycle.
- R3: In any cycle where `m_tvalid` is 1 and `m_tready` is 0, `src_ready` is 0.
- R4: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` at 1 and holds `m_tdata` and `m_tlast` unchanged.
- R5: `m_tlast` is 1 on exactly the output word that makes the number of accepted words equal to the frame length. The count then restarts at zero, so with length L the marker falls on words L, 2L, 3L and so on.
- R6: A frame length of 1 marks every word. A written length of 0 acts as 1.
- R7: A write on `cfg_we` loads `cfg_len` and clears the word count. A word accepted in the same cycle as the write is the first word counted under the new length.
- R8: `src_last` has no effect on any output.
- R9: A word accepted while the output stage is empty shows on `m_tvalid`/`m_tdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Producer word strobe |
| src_data | input | DATA_W | Producer word |
| src_last | input | 1 | Producer end-of-frame flag, discarded |
| src_ready | output | 1 | Enable to the producer |
| cfg_we | input | 1 | Frame length write strobe |
| cfg_len | input | LEN_W | Frame length value to write |
| m_tvalid | output | 1 | Stream valid |
| m_tdata | output | DATA_W | Stream data |
| m_tlast | output | 1 | Stream end-of-frame marker |
| m_tready | input | 1 | Stream ready from the sink |

## Verification
The bench drives a producer model that obeys the enable one cycle late. Against a stalling sink, this forces the spare register into use. A design without that slot, or one that clears it wrongly, drops or repeats a word at each stall. Mid-frame length writes, both alone and in the same cycle as a word, check where the marker lands. A counter that is not cleared, or that counts the write-cycle word under the old length, puts the marker one frame late or one word off. Lengths 1 and 0 are tried, since a clamp that is missing leaves a zero length that never marks. A constant incoming end-of-frame flag is also applied, to catch a design that passes it through.

// File: rtl/strm_adapt_pkg.sv
`timescale 1ns/1ps
package strm_adapt_pkg;

   // occupancy of the two-register output path
   typedef enum logic [1:0] {
      FILL_NONE = 2'd0,
      FILL_OUT  = 2'd1,
      FILL_BOTH = 2'd2
   } fill_e;

endpackage

// File: rtl/strm_frame_counter.sv
`timescale 1ns/1ps
module strm_frame_counter #(
   parameter int LEN_W   = 8,
   parameter int DEF_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             cfg_we,
   input  logic [LEN_W-1:0] cfg_len,
   output logic             last_o,
   output logic [LEN_W-1:0] cnt_o,
   output logic [LEN_W-1:0] len_o
);

   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
   localparam logic [LEN_W-1:0] DEF_EFF = (DEF_LEN == 0) ? ONE : LEN_W'(DEF_LEN);

   generate
      if (LEN_W == 1) begin : g_unit
         // only lengths 0 and 1 exist; both mark every word
         logic unused_cfg;
         assign unused_cfg = ^{clk, rst_n, beat, cfg_we, cfg_len};
         assign last_o = 1'b1;
         assign cnt_o  = '0;
         assign len_o  = ONE;
      end else begin : g_count
         logic [LEN_W-1:0] len_q, cnt_q;
         logic [LEN_W-1:0] len_eff, base, nxt;

         always_comb begin
            len_eff = len_q;
            base    = cnt_q;
            if (cfg_we) begin
               len_eff = (cfg_len == '0) ? ONE : cfg_len;
               base    = '0;
            end
            nxt    = base + ONE;
            last_o = (nxt == len_eff);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               len_q <= DEF_EFF;
               cnt_q <= '0;
            end else begin
               if (cfg_we)
                  len_q <= len_eff;
               if (beat)
                  cnt_q <= last_o ? '0 : nxt;
               else if (cfg_we)
                  cnt_q <= '0;
            end
         end

         assign cnt_o = cnt_q;
         assign len_o = len_q;
      end
   endgenerate

endmodule

// File: rtl/strm_skid_pipe.sv
`timescale 1ns/1ps
module strm_skid_pipe #(
   parameter int PAY_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  logic [PAY_W-1:0] in_pay,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [PAY_W-1:0] out_pay,
   output logic             can_take,
   output logic             skid_full
);
   import strm_adapt_pkg::*;

   fill_e            fill_q;
   logic [PAY_W-1:0] out_q, spare_q;
   logic             out_free;

   assign out_free  = (fill_q == FILL_NONE) || out_ready;
   assign can_take  = (fill_q != FILL_BOTH) && out_free;
   assign out_valid = (fill_q != FILL_NONE);
   assign skid_full = (fill_q == FILL_BOTH);
   assign out_pay   = out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= FILL_NONE;
         out_q   <= '0;
         spare_q <= '0;
      end else begin
         unique case (fill_q)
            FILL_NONE: begin
               if (in_fire) begin
                  out_q  <= in_pay;
                  fill_q <= FILL_OUT;
               end
            end
            FILL_OUT: begin
               if (out_ready) begin
                  if (in_fire) out_q <= in_pay;
                  else         fill_q <= FILL_NONE;
               end else if (in_fire) begin
                  spare_q <= in_pay;
                  fill_q  <= FILL_BOTH;
               end
            end
            FILL_BOTH: begin
               if (out_ready) begin
                  out_q <= spare_q;
                  if (in_fire) spare_q <= in_pay;
                  else         fill_q  <= FILL_OUT;
               end
            end
            default: fill_q <= FILL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/strm_frame_adapter.sv
`timescale 1ns/1ps
module strm_frame_adapter #(
   parameter int DATA_W  = 16,
   parameter int LEN_W   = 8,
   parameter int DEF_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_last,
   output logic              src_ready,
   input  logic              cfg_we,
   input  logic [LEN_W-1:0]  cfg_len,
   output logic              m_tvalid,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tlast,
   input  logic              m_tready
);

   localparam int PAY_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (LEN_W < 1 || LEN_W > 30) begin : g_bad_len
         $error("LEN_W must be between 1 and 30");
      end
      if (DEF_LEN < 0 || DEF_LEN >= (1 << LEN_W)) begin : g_bad_def
         $error("DEF_LEN does not fit LEN_W");
      end
   endgenerate

   logic             word_last;
   logic [LEN_W-1:0] cnt_w, len_w;
   logic [PAY_W-1:0] pay_in, pay_out;
   logic             skid_full_w;
   logic             unused_src_last;

   assign unused_src_last = src_last;

   strm_frame_counter #(
      .LEN_W   (LEN_W),
      .DEF_LEN (DEF_LEN)
   ) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (src_valid),
      .cfg_we  (cfg_we),
      .cfg_len (cfg_len),
      .last_o  (word_last),
      .cnt_o   (cnt_w),
      .len_o   (len_w)
   );

   assign pay_in = {word_last, src_data};

   strm_skid_pipe #(
      .PAY_W (PAY_W)
   ) i_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_fire   (src_valid),
      .in_pay    (pay_in),
      .out_ready (m_tready),
      .out_valid (m_tvalid),
      .out_pay   (pay_out),
      .can_take  (src_ready),
      .skid_full (skid_full_w)
   );

   assign m_tdata = pay_out[DATA_W-1:0];
   assign m_tlast = pay_out[DATA_W];

endmodule

// File: rtl/strm_frame_adapter_chk.sv
`timescale 1ns/1ps
module strm_frame_adapter_chk #(
   parameter int DATA_W = 16,
   parameter int LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_valid,
   input logic              src_ready,
   input logic              cfg_we,
   input logic              m_tvalid,
   input logic [DATA_W-1:0] m_tdata,
   input logic              m_tlast,
   input logic              m_tready,
   input logic [LEN_W-1:0]  cnt_w,
   input logic [LEN_W-1:0]  len_w,
   input logic              skid_full_w
);

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!m_tvalid && src_ready));

   a_r2_grace_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && $past(src_ready)) |-> !(skid_full_w && m_tvalid && !m_tready));

   a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |-> !src_ready);

   a_r4_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

   a_r5_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w < len_w) && (len_w != '0));

   a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !src_valid) |=> (cnt_w == '0));

endmodule

bind strm_frame_adapter strm_frame_adapter_chk #(
   .DATA_W (DATA_W),
   .LEN_W  (LEN_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_valid   (src_valid),
   .src_ready   (src_ready),
   .cfg_we      (cfg_we),
   .m_tvalid    (m_tvalid),
   .m_tdata     (m_tdata),
   .m_tlast     (m_tlast),
   .m_tready    (m_tready),
   .cnt_w       (cnt_w),
   .len_w       (len_w),
   .skid_full_w (skid_full_w)
);

// File: tb/test_strm_frame_adapter.sv
`timescale 1ns/1ps
module test_strm_frame_adapter;

   localparam int DW = 16;
   localparam int LW = 8;
   localparam int DEF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          src_valid = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          src_last = 1'b0;
   logic          src_ready;
   logic          cfg_we = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic          m_tvalid;
   logic [DW-1:0] m_tdata;
   logic          m_tlast;
   logic          m_tready = 1'b0;

   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;
   logic [DW-1:0] seq = 16'h0100;
   bit            rdy_prev = 1'b0;
   int            mlen = DEF;
   int            mcnt = 0;
   logic [DW:0]   expq[$];
   bit            hold_valid = 1'b0;
   logic [DW-1:0] hold_data;
   logic          hold_last;
   string         cur_req = "R5";

   always #2.5 clk = ~clk;

   strm_frame_adapter #(.DATA_W(DW), .LEN_W(LW), .DEF_LEN(DEF)) i_strm_frame_adapter (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_last(src_last), .src_ready(src_ready), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tready(m_tready)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, sample just after
   task automatic cycle(input bit want, input bit lst, input bit trdy,
                        input bit we, input int l);
      logic        lb;
      logic [DW:0] e;
      @(negedge clk);
      src_valid = want && rdy_prev;
      src_data  = seq;
      src_last  = lst;
      m_tready  = trdy;
      cfg_we    = we;
      cfg_len   = l[LW-1:0];
      #1;
      if (we) begin
         mlen = (l == 0) ? 1 : l;
         mcnt = 0;
      end
      if (src_valid) begin
         mcnt++;
         lb = (mcnt == mlen);
         if (lb) mcnt = 0;
         expq.push_back({lb, seq});
         seq++;
      end
      if (m_tvalid && !m_tready)
         check(!src_ready, "R3", "src_ready while stalled", {31'd0, src_ready}, 0);
      if (hold_valid)
         check(m_tvalid && m_tdata == hold_data && m_tlast == hold_last, "R4",
               "held output changed", {15'd0, m_tlast, m_tdata}, {15'd0, hold_last, hold_data});
      hold_valid = m_tvalid && !m_tready;
      hold_data  = m_tdata;
      hold_last  = m_tlast;
      if (m_tvalid && m_tready) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2", "unexpected output word", {16'd0, m_tdata}, 0);
         end else begin
            e = expq.pop_front();
            check(m_tdata == e[DW-1:0], "R2", "output word", {16'd0, m_tdata}, {16'd0, e[DW-1:0]});
            check(m_tlast == e[DW], cur_req, "end-of-frame marker", {31'd0, m_tlast}, {31'd0, e[DW]});
         end
      end
      rdy_prev = src_ready;
   endtask

   task automatic drain();
      for (int i = 0; i < 40 && expq.size() != 0; i++)
         cycle(1'b0, 1'b0, 1'b1, 1'b0, 0);
      check(expq.size() == 0, "R2", "words left undelivered", expq.size(), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(!m_tvalid, "R1", "m_tvalid in reset", {31'd0, m_tvalid}, 0);
      check(src_ready, "R1", "src_ready in reset", {31'd0, src_ready}, 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(!m_tvalid && src_ready, "R1", "state after reset",
            {30'd0, m_tvalid, src_ready}, 1);
   endtask

   task automatic t_latency();
      cur_req = "R5";
      cycle(1'b0, 1'b0, 1'b1, 1'b0, 0);
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
      check(!m_tvalid, "R9", "output before capture edge", {31'd0, m_tvalid}, 0);
      cycle(1'b0, 1'b0, 1'b1, 1'b0, 0);
      check(m_tvalid && m_tdata == seq - 1, "R9", "word one cycle later",
            {15'd0, m_tvalid, m_tdata}, {15'd1, seq - 16'd1});
      drain();
   endtask

   task automatic t_free_run();
      cur_req = "R5";
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 4);
      for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
      drain();
   endtask

   task automatic t_backpressure();
      cur_req = "R5";
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 3);
      for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, (i % 5) < 2, 1'b0, 0);
      for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, (i % 2) == 0, 1'b0, 0);
      drain();
   endtask

   task automatic t_small_len();
      int marks;
      cur_req = "R6";
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 1);
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
      drain();
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 0);
      marks = 0;
      for (int i = 0; i < 6; i++) begin
         cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
         if (m_tvalid && m_tlast) marks++;
      end
      check(marks >= 4, "R6", "zero length marks each word", marks, 4);
      drain();
   endtask

   task automatic t_midframe();
      cur_req = "R7";
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 6);
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
      cycle(1'b0, 1'b0, 1'b1, 1'b1, 3);
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 1'b1, 1'b0, 0);
      cycle(1'b1, 1'b0, 1'b0, 1'b1, 4);
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, i > 1, 1'b0, 0);
      drain();
   endtask

   task automatic t_ignore_last();
      cur_req = "R8";
      cycle(1'b0, 1'b1, 1'b1, 1'b1, 5);
      for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0, 0);
      for (int i = 0; i < 6; i++) cycle(1'b1, (i % 2) == 1, 1'b1, 1'b0, 0);
      drain();
   endtask

   initial begin
      t_reset();
      t_latency();
      t_free_run();
      t_backpressure();
      t_small_len();
      t_midframe();
      t_ignore_last();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule